// File: doc/BRIEF.md
# Daisy-Chained Serial Control-Register Slave

This block is the device-side end of a slow serial port that sets up and inspects a handful of 16-bit control registers in a memory device. A shared serial clock and a shared framing line reach every device in parallel. Two data pins per device form a chain. The upstream pin faces the controller and the downstream pin faces the next device. While a transaction is outside its read-reply slot, each device copies what it receives upstream onto its downstream pin, so every device sees every request.

A transaction opens with a fixed pattern on the framing line. Four 16-bit packets follow: a request, a register address, and then either data followed by an interval (write) or an interval followed by data (read). The addressed device answers a read by driving its reply toward the controller. Every other device on the chain turns its pins around and hands the downstream reply upward.

The serial clock and framing line are treated as slow data inputs, oversampled by the block's system clock. The block detects their rising and falling transitions and acts on those. Pad tristate behaviour is outside the block, so each data pin appears as an input, an output value and an output enable.

Top module: `serial_cfg_slave`

## Requirements
- R1: A transaction starts when the last eight framing-line samples, taken on both the rising and the falling serial-clock transitions, read 1,1,1,1,0,0,0,0 oldest first. A near-miss such as 1,1,1,0,0,0,0,0 starts nothing. The first packet bit is sampled on the next falling transition, and each packet is sent most significant bit first.
- R2: Each transaction is four 16-bit packets, with data-pin bits sampled only on falling transitions. In the request packet, bits 15:12 are the opcode, bit 11 is the broadcast flag and bits 4:0 are the device number; bits 10:5 are ignored. Bits 11:0 of the second packet are the register address. Opcode 0001 is a write (request, address, data, interval) and opcode 0000 is a read (request, address, interval, data).
- R3: A write is stored when the last bit of the data packet is sampled. It takes effect only if the device number equals the device's own identifier (the DEV_ID parameter, loaded at reset) or the broadcast flag is set.
- R4: Addresses from NREG upward are unimplemented: writes to them change nothing, and reads of them return zero.
- R5: Outside the read-reply window, the downstream output equals the upstream input and the downstream enable is 1. Inside that window the downstream enable is 0.
- R6: For a read whose device number matches exactly with broadcast clear, the upstream enable rises at the falling transition that samples the last interval bit. The device then drives, on successive falling transitions, 0, the register bits 15 down to 0, and a trailing 0. It releases the pin on the following falling transition.
- R7: For a read that is broadcast or names another device, the upstream enable follows the same window as in R6, and the upstream output copies the downstream input.
- R8: A frame pattern seen in the middle of a transaction restarts the packet count at zero. A write cut short this way before its data packet is complete changes no register.
- R9: After reset all registers read zero, the upstream enable is 0 and the downstream pin repeats the upstream input.
- R10: Opcodes other than 0000 and 0001 change no register and open no reply window. All four packets are repeated downstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Shared serial clock |
| cmd_i | input | 1 | Shared framing line |
| sio_up_i | input | 1 | Upstream data pin, input side |
| sio_up_o | output | 1 | Upstream data pin, output value |
| sio_up_oe_o | output | 1 | Upstream data pin, output enable |
| sio_dn_i | input | 1 | Downstream data pin, input side |
| sio_dn_o | output | 1 | Downstream data pin, output value |
| sio_dn_oe_o | output | 1 | Downstream data pin, output enable |

## Verification
The hardest state to reach from the pins is a reframe that arrives after a write has sent its data bits but before the final one. It must leave the register file untouched and still let the following transaction run normally. The bench reaches it directly by cutting a write short at bit 40 and framing a new read of the same register at once. The reply window is also narrow: it opens and closes exactly one falling transition before and after the data slot. For that reason every serial cycle of every transaction is checked on both pins. Random requests mix the own identifier, foreign identifiers, broadcast, unimplemented addresses and undefined opcodes, and random bits fill the ignored request field.

// File: rtl/scs_pkg.sv
// Shared constants and types for the serial control-register slave.
// Assumes a four-packet transaction of fixed 16-bit packets.
package scs_pkg;
    localparam int PKT_W     = 16;
    localparam int ADDR_W    = 12;
    localparam int DEV_W     = 5;
    localparam int OP_W      = 4;
    localparam int N_PKT     = 4;
    localparam int FRAME_LEN = 8;
    localparam logic [FRAME_LEN-1:0] FRAME_PAT = 8'b1111_0000;

    localparam logic [OP_W-1:0] OP_WRITE = 4'b0001;
    localparam logic [OP_W-1:0] OP_READ  = 4'b0000;

    // falling-edge sequence numbers within one transaction
    localparam int XACT_BITS = PKT_W * N_PKT;       // data bits sampled
    localparam int SEQ_LAST  = XACT_BITS + 1;       // release step
    localparam int CNT_W     = $clog2(SEQ_LAST + 1);

    localparam logic [CNT_W-1:0] SEQ_REQ_END  = CNT_W'(PKT_W - 1);
    localparam logic [CNT_W-1:0] SEQ_ADR_END  = CNT_W'(2 * PKT_W - 1);
    localparam logic [CNT_W-1:0] SEQ_P3_END   = CNT_W'(3 * PKT_W - 1);
    localparam logic [CNT_W-1:0] SEQ_TRAIL    = CNT_W'(XACT_BITS);
    localparam logic [CNT_W-1:0] SEQ_RELEASE  = CNT_W'(SEQ_LAST);

    // decoded request fields kept after the request packet
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic             bcast;
        logic [DEV_W-1:0] dev;
    } req_t;
endpackage

// File: rtl/scs_edge_frame.sv
// Serial-clock edge detector and frame-pattern matcher.
// Assumes sck_i and cmd_i are already synchronous to clk and change
// slowly enough that every level lasts at least two clk cycles.
module scs_edge_frame
    import scs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cmd_i,
    output logic fall_o,
    output logic frame_o
);
    logic                 sck_q;
    logic [FRAME_LEN-1:0] cmd_sr;
    logic [FRAME_LEN-1:0] cmd_nxt;
    logic                 edge_ev;

    // Previous serial-clock level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= sck_i;
        else        sck_q <= sck_i;
    end

    // Transition strobes and the candidate framing history.
    always_comb begin
        fall_o  = sck_q & ~sck_i;
        edge_ev = sck_q ^ sck_i;
        cmd_nxt = {cmd_sr[FRAME_LEN-2:0], cmd_i};
        frame_o = edge_ev && (cmd_nxt == FRAME_PAT);
    end

    // Shift one framing sample in on every serial-clock transition.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_sr <= '0;
        else if (edge_ev) cmd_sr <= cmd_nxt;
    end
endmodule

// File: rtl/scs_regfile.sv
// Bank of NREG 16-bit control registers with one write and one read port.
// Addresses at or above NREG read as zero and absorb writes.
module scs_regfile
    import scs_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [PKT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [PKT_W-1:0]  rd_data_o
);
    logic [NREG*PKT_W-1:0] flat;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [PKT_W-1:0] q;
        // Register i: cleared at reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    q <= '0;
            else if (wr_en_i && wr_addr_i == ADDR_W'(i))   q <= wr_data_i;
        end
        assign flat[i*PKT_W +: PKT_W] = q;
    end

    // Read mux; no match leaves zero for unimplemented addresses.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = flat[i*PKT_W +: PKT_W];
        end
    end
endmodule

// File: rtl/scs_sequencer.sv
// Transaction sequencer: counts falling serial-clock transitions after a
// frame, shifts packets in, decodes the request and schedules the write
// strobe and the read-reply window. Assumes fall_i and frame_i are
// single-cycle strobes from scs_edge_frame.
module scs_sequencer
    import scs_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 5'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              frame_i,
    input  logic              sio_i,
    input  logic [PKT_W-1:0]  rd_data_i,
    output logic              busy_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [PKT_W-1:0]  wr_data_o,
    output logic              win_o,
    output logic              own_o,
    output logic              drv_o
);
    logic [DEV_W-1:0] dev_id_q;
    logic [PKT_W-1:0] sh_q;
    logic [PKT_W-1:0] sh_nxt;
    logic [PKT_W-1:0] rd_q;
    req_t             req_q;
    logic             step;
    logic             dev_hit;
    logic             is_rd;
    logic             reply_go;

    // Own identifier, fixed by parameter at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_id_q <= DEV_ID;
    end

    // Per-fall decisions derived from the count and the decoded request.
    always_comb begin
        step      = fall_i && busy_o && !frame_i;
        sh_nxt    = {sh_q[PKT_W-2:0], sio_i};
        dev_hit   = (req_q.dev == dev_id_q);
        is_rd     = (req_q.op == OP_READ);
        reply_go  = is_rd && (cnt_o >= SEQ_P3_END) && (cnt_o <= SEQ_TRAIL);
        wr_en_o   = step && (cnt_o == SEQ_P3_END) && (req_q.op == OP_WRITE)
                    && (dev_hit || req_q.bcast);
        wr_data_o = sh_nxt;
    end

    // Counter, packet capture and reply-window scheduling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
            sh_q   <= '0;
            req_q  <= '0;
            addr_o <= '0;
            rd_q   <= '0;
            win_o  <= 1'b0;
            own_o  <= 1'b0;
            drv_o  <= 1'b0;
        end else if (frame_i) begin
            busy_o <= 1'b1;
            cnt_o  <= '0;
            win_o  <= 1'b0;
        end else if (step) begin
            sh_q  <= sh_nxt;
            cnt_o <= cnt_o + 1'b1;
            win_o <= reply_go;
            if (cnt_o == SEQ_REQ_END) begin
                req_q.op    <= sh_nxt[PKT_W-1 -: OP_W];
                req_q.bcast <= sh_nxt[PKT_W-1-OP_W];
                req_q.dev   <= sh_nxt[DEV_W-1:0];
            end
            if (cnt_o == SEQ_ADR_END) addr_o <= sh_nxt[ADDR_W-1:0];
            if (cnt_o == SEQ_P3_END) begin
                rd_q  <= rd_data_i;
                drv_o <= 1'b0;
                own_o <= is_rd && dev_hit && !req_q.bcast;
            end else if (cnt_o < SEQ_TRAIL) begin
                drv_o <= rd_q[PKT_W-1];
                rd_q  <= {rd_q[PKT_W-2:0], 1'b0};
            end else begin
                drv_o <= 1'b0;
            end
            if (cnt_o == SEQ_RELEASE) busy_o <= 1'b0;
        end else if (fall_i) begin
            win_o <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_cfg_slave.sv
// Top of the daisy-chained serial control-register slave. Ties the edge
// and frame detector, the sequencer and the register bank together and
// steers the two chain pins. Assumes external pads honour the enables.
module serial_cfg_slave
    import scs_pkg::*;
#(
    parameter int               NREG   = 4,
    parameter logic [DEV_W-1:0] DEV_ID = 5'd3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cmd_i,
    input  logic sio_up_i,
    output logic sio_up_o,
    output logic sio_up_oe_o,
    input  logic sio_dn_i,
    output logic sio_dn_o,
    output logic sio_dn_oe_o
);
    logic              fall_ev;
    logic              frame_ev;
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [PKT_W-1:0]  wr_data;
    logic [PKT_W-1:0]  rd_data;
    logic              win;
    logic              own;
    logic              drv;

    scs_edge_frame u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck_i),
        .cmd_i   (cmd_i),
        .fall_o  (fall_ev),
        .frame_o (frame_ev)
    );

    scs_sequencer #(.DEV_ID(DEV_ID)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall_ev),
        .frame_i   (frame_ev),
        .sio_i     (sio_up_i),
        .rd_data_i (rd_data),
        .busy_o    (busy),
        .cnt_o     (cnt),
        .addr_o    (addr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .win_o     (win),
        .own_o     (own),
        .drv_o     (drv)
    );

    scs_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (addr),
        .wr_data_i (wr_data),
        .rd_addr_i (addr),
        .rd_data_o (rd_data)
    );

    // Pin steering: repeat downstream, or turn around for the reply.
    always_comb begin
        sio_dn_o    = sio_up_i;
        sio_dn_oe_o = ~win;
        sio_up_oe_o = win;
        sio_up_o    = own ? drv : sio_dn_i;
    end
endmodule

// File: rtl/scs_chk.sv
// Protocol checker for serial_cfg_slave, attached by bind below.
module scs_chk
    import scs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sck_i,
    input logic             fall_ev,
    input logic             frame_ev,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             sio_up_oe_o,
    input logic             sio_dn_oe_o
);
    // R6
    oe_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_up_oe_o != $past(sio_up_oe_o)) |-> ($past(sck_i) == 1'b0 && $past(sck_i, 2) == 1'b1));
    // R8
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ev |=> (busy && cnt == '0));
    // R5
    idle_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sio_dn_oe_o);
    // R6
    no_early_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt <= SEQ_P3_END) |-> !sio_up_oe_o);
    // R2
    count_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_ev && !fall_ev) |=> $stable(cnt));
    // R7
    reply_inside_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sio_up_oe_o |-> busy);
endmodule

bind serial_cfg_slave scs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_i       (sck_i),
    .fall_ev     (fall_ev),
    .frame_ev    (frame_ev),
    .busy        (busy),
    .cnt         (cnt),
    .sio_up_oe_o (sio_up_oe_o),
    .sio_dn_oe_o (sio_dn_oe_o)
);

// File: tb/serial_cfg_slave_test.sv
// Bench for serial_cfg_slave: directed corners plus seeded random traffic.
module serial_cfg_slave_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         NREG       = 4;
    localparam logic [4:0] DEV        = 5'd3;
    localparam logic [3:0] OP_RD      = 4'b0000;
    localparam logic [3:0] OP_WR      = 4'b0001;
    localparam int         FULL       = 67;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cmd = 1'b0, up_i = 1'b0, dn_i = 1'b0;
    logic up_o, up_oe, dn_o, dn_oe;
    logic s_up_o, s_up_oe, s_dn_o, s_dn_oe;
    int   n_chk = 0, n_fail = 0;
    logic [15:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_slave #(.NREG(NREG), .DEV_ID(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cmd_i(cmd),
        .sio_up_i(up_i), .sio_up_o(up_o), .sio_up_oe_o(up_oe),
        .sio_dn_i(dn_i), .sio_dn_o(dn_o), .sio_dn_oe_o(dn_oe)
    );

    task automatic check(input logic ok, input string r, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, a, e);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [11:0] a);
        return (a < NREG) ? model[a[1:0]] : 16'h0;
    endfunction

    function automatic logic exp_bit(input logic [15:0] d, input int c);
        if (c == 48 || c == 65) return 1'b0;
        return d[64 - c];
    endfunction

    function automatic logic [15:0] mkreq(input logic [3:0] op, input logic bc, input logic [4:0] dv, input logic [5:0] junk);
        return {op, bc, junk, dv};
    endfunction

    // One serial clock cycle; outputs captured just before the fall.
    task automatic sck_cycle(input logic cr, input logic cf, input logic d, input logic dv);
        cmd = cr;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        cmd = cf; up_i = d; dn_i = dv;
        repeat (2) @(negedge clk);
        s_up_o = up_o; s_up_oe = up_oe; s_dn_o = dn_o; s_dn_oe = dn_oe;
        sck = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xact(input logic good, input logic [15:0] p0, input logic [15:0] p1,
                        input logic [15:0] p2, input logic [15:0] p3, input int ncyc, input string rq);
        logic [63:0] all;
        logic rd, own, b, dv, win, e;
        logic [15:0] d;
        string base;
        all = {p0, p1, p2, p3};
        rd  = good && p0[15:12] == OP_RD;
        own = rd && p0[4:0] == DEV && !p0[11];
        d   = model_rd(p1[11:0]);
        sck_cycle(1'b1, 1'b1, 1'b0, 1'b0);
        if (good) sck_cycle(1'b1, 1'b1, 1'b0, 1'b0);
        else      sck_cycle(1'b1, 1'b0, 1'b0, 1'b0);
        sck_cycle(1'b0, 1'b0, 1'b0, 1'b0);
        sck_cycle(1'b0, 1'b0, 1'b0, 1'b0);
        for (int c = 0; c < ncyc; c++) begin
            b  = (c < 64) ? all[63 - c] : 1'($urandom % 2);
            dv = 1'($urandom % 2);
            sck_cycle(1'b0, 1'b0, b, dv);
            win  = rd && c >= 48 && c <= 65;
            base = rd ? (own ? "R6" : "R7") : "R10";
            check(s_up_oe === win, $sformatf("%s %s up_oe c=%0d", base, rq, c), s_up_oe, win);
            if (win) begin
                check(s_dn_oe === 1'b0, $sformatf("R5 %s dn_oe c=%0d", rq, c), s_dn_oe, 0);
                e = own ? exp_bit(d, c) : dv;
                check(s_up_o === e, $sformatf("%s %s up_o c=%0d", base, rq, c), s_up_o, e);
            end else begin
                check({s_dn_oe, s_dn_o} === {1'b1, b}, $sformatf("R5 %s repeat c=%0d", rq, c),
                      {s_dn_oe, s_dn_o}, {1'b1, b});
            end
        end
        if (good && ncyc >= 48 && p0[15:12] == OP_WR && (p0[4:0] == DEV || p0[11]) && p1[11:0] < NREG)
            model[p1[1:0]] = p2;
    endtask

    task automatic rd_own(input logic [11:0] a, input string rq);
        xact(1'b1, mkreq(OP_RD, 1'b0, DEV, 6'h0), {4'h0, a}, 16'h0, 16'h0, FULL, rq);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5A17);
        for (int i = 0; i < NREG; i++) model[i] = 16'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state at the pins
        check(up_oe === 1'b0, "R9 up_oe", up_oe, 0);
        check(dn_oe === 1'b1, "R9 dn_oe", dn_oe, 1);
        up_i = 1'b1; @(negedge clk);
        check(dn_o === 1'b1, "R9 dn repeat", dn_o, 1);
        up_i = 1'b0;
        for (int a = 0; a < NREG; a++) rd_own(12'(a), "R9");
        // R3 own write then own read
        xact(1'b1, mkreq(OP_WR, 1'b0, DEV, 6'h2A), 16'h0001, 16'hBEEF, 16'h0, FULL, "R3");
        rd_own(12'h001, "R3");
        // R3 broadcast write, R7 broadcast read passes downstream reply
        xact(1'b1, mkreq(OP_WR, 1'b1, 5'd17, 6'h0), 16'h0002, 16'h1234, 16'h0, FULL, "R3");
        xact(1'b1, mkreq(OP_RD, 1'b1, DEV, 6'h0), 16'h0002, 16'h0, 16'h0, FULL, "R7");
        rd_own(12'h002, "R3");
        // R4 unimplemented address
        xact(1'b1, mkreq(OP_WR, 1'b0, DEV, 6'h0), 16'h0007, 16'hFFFF, 16'h0, FULL, "R4");
        rd_own(12'h007, "R4");
        for (int a = 0; a < NREG; a++) rd_own(12'(a), "R4");
        // R3 foreign write ignored, R7 foreign read passes
        xact(1'b1, mkreq(OP_WR, 1'b0, 5'd4, 6'h0), 16'h0001, 16'h0BAD, 16'h0, FULL, "R3");
        xact(1'b1, mkreq(OP_RD, 1'b0, 5'd4, 6'h0), 16'h0001, 16'h0, 16'h0, FULL, "R7");
        rd_own(12'h001, "R3");
        // R8 write cut off before its last data bit, then reframe
        xact(1'b1, mkreq(OP_WR, 1'b0, DEV, 6'h0), 16'h0001, 16'h5555, 16'h0, 40, "R8");
        rd_own(12'h001, "R8");
        // R10 undefined opcode
        xact(1'b1, mkreq(4'b0101, 1'b0, DEV, 6'h0), 16'h0003, 16'hAAAA, 16'h0, FULL, "R10");
        rd_own(12'h003, "R10");
        // R1 near-miss frame starts nothing
        xact(1'b0, mkreq(OP_WR, 1'b0, DEV, 6'h0), 16'h0000, 16'h7777, 16'h0, FULL, "R1");
        rd_own(12'h000, "R1");
        // R2 random traffic with random ignored request bits
        for (int k = 0; k < 40; k++) begin
            logic [3:0] op;
            logic [4:0] dv;
            int sel;
            sel = $urandom % 5;
            op  = (sel < 2) ? OP_WR : (sel < 4) ? OP_RD : 4'($urandom % 16);
            dv  = ($urandom % 2) ? DEV : 5'($urandom % 32);
            xact(1'b1, mkreq(op, ($urandom % 4) == 0, dv, 6'($urandom)),
                 {4'($urandom), 12'($urandom % 6)}, 16'($urandom), 16'($urandom), FULL, "R2");
        end
        for (int a = 0; a < NREG; a++) rd_own(12'(a), "R2");
        finish_run();
    end
endmodule